// File: doc/BRIEF.md
# Three-Channel Transfer Control and Arbitration

This block holds the shared control state for three transfer channels and picks which channel engine may move data. Each channel chooses one line of a 16-line trigger bus. A rising edge on that line makes the channel pending, and so does a software request. A small register port gives access to the select fields, a global mode register, a command register and one control register per channel.

When several channels are pending, an arbiter grants one of them. In fixed mode channel 0 wins first, then 1, then 2. In rotating mode the channel served last drops to the lowest rank. A global mode bit can hold new grants back until the processor signals an instruction fetch. A second mode bit lets an NMI abort the granted channel. The engine still finishes the unit it is moving, and the channel then stops.

Completion sets a sticky per-channel flag, and one interrupt line combines the flags with their enables. The engines that move the data are outside this block. They report `unit_done` for each unit and `xfer_last` when a unit is the final one of the count.

Top module: `dma_chan_arbiter`

## Requirements
- R1: Register 0 holds the trigger selects, with channel i in bits [4i+3:4i]. Channel i watches `trig_bus[select_i]`. That line being low on one clock edge and high on the next makes an enabled channel pending.
- R2: A write to register 0 leaves unchanged the select field of every channel whose enable bit is 1. The fields of the other channels take the written value.
- R3: When the rotate bit (register 1 bit 0) is 0, the grant goes to the lowest-numbered eligible channel.
- R4: When the rotate bit is 1, the eligible channels are ranked starting from the one after the last channel served, wrapping around. The last channel served therefore ranks lowest. After reset the last channel served counts as channel 2.
- R5: When the fetch-wait bit (register 1 bit 1) is 1, a new grant is issued only on a clock edge where `ifetch` is 1.
- R6: `grant` is one-hot or zero. A grant is issued one edge after the channel becomes pending. It holds until a `unit_done` edge, and it is 0 on the following cycle.
- R7: A `unit_done` with `xfer_last` sets the granted channel's flag (control bit 2) and clears its enable (bit 0). The flag stays at 1 until software writes a 0 to it.
- R8: `irq` is 1 exactly when some channel has both its flag and its interrupt enable (control bit 1) set.
- R9: When the NMI-enable bit (register 1 bit 2) is 1, `nmi` sets the abort bit (control bit 3) of the granted channel. The next `unit_done` then sets the flag and clears the enable. When the NMI-enable bit is 0, `nmi` has no effect.
- R10: Writing register 2 with bit 0 set zeroes registers 0 and 1. Writing it with bit 4+i set zeroes channel i's control register.
- R11: A write to channel i's control register (address 4+i) with bit 4 set makes the channel pending if its enable bit was already 1. Bit 4 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| trig_bus | input | 16 | Hardware trigger lines |
| nmi | input | 1 | Non-maskable interrupt request |
| ifetch | input | 1 | Instruction-fetch strobe |
| unit_done | input | 1 | The granted engine finished one unit |
| xfer_last | input | 1 | The finished unit was the final one |
| grant | output | 3 | One-hot channel grant |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes are visible on `reg_rdata` at the first falling edge after the writing edge. A software request or trigger edge becomes pending on that edge, and the grant appears one edge later. The bench therefore samples grants two falling edges after a trigger change, or one falling edge after a request write returns. The effects of `unit_done` and `nmi` are due on the edge that samples them, so the bench reads the flags, the enables and `grant` at the falling edge just after it. The bench model of the last channel served tracks every completion, so random trigger patterns in both priority modes are checked against a computed winner.

// File: rtl/dca_pkg.sv
// Shared constants: register map and bit positions of the control block.
package dca_pkg;
    localparam int DW = 16;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_SEL = 3'd0;
    localparam logic [AW-1:0] A_GLB = 3'd1;
    localparam logic [AW-1:0] A_CMD = 3'd2;
    localparam logic [AW-1:0] A_CH0 = 3'd4;

    localparam int GB_ROT   = 0;
    localparam int GB_FETCH = 1;
    localparam int GB_NMI   = 2;

    localparam int CB_EN  = 0;
    localparam int CB_IE  = 1;
    localparam int CB_IFG = 2;
    localparam int CB_ABT = 3;
    localparam int CB_REQ = 4;

    localparam int CMD_GRST  = 0;
    localparam int CMD_CRST0 = 4;
endpackage

// File: rtl/dca_regs.sv
// Register file: trigger selects, global mode bits and per-channel control.
// Assumes one access per cycle; hardware set/clear inputs win over a write.
module dca_regs
    import dca_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    input  logic [NCH-1:0]       hw_done,
    input  logic [NCH-1:0]       hw_abort,
    output logic [NCH*SEL_W-1:0] sel,
    output logic                 rot,
    output logic                 fetch_wait,
    output logic                 nmi_en,
    output logic [NCH-1:0]       en,
    output logic [NCH-1:0]       ie,
    output logic [NCH-1:0]       ifg,
    output logic [NCH-1:0]       abort_f,
    output logic [NCH-1:0]       sw_req,
    output logic [DW-1:0]        rdata
);
    localparam int SELS_W = NCH * SEL_W;

    logic sel_wr, glb_wr, cmd_wr, grst;
    logic unused_wbits;

    assign sel_wr = wr && (addr == A_SEL);
    assign glb_wr = wr && (addr == A_GLB);
    assign cmd_wr = wr && (addr == A_CMD);
    assign grst   = cmd_wr && wdata[CMD_GRST];
    assign unused_wbits = ^wdata[DW-1:SELS_W];

    // Global mode register.
    always_ff @(posedge clk) begin
        if (!rst_n || grst) begin
            rot        <= 1'b0;
            fetch_wait <= 1'b0;
            nmi_en     <= 1'b0;
        end else if (glb_wr) begin
            rot        <= wdata[GB_ROT];
            fetch_wait <= wdata[GB_FETCH];
            nmi_en     <= wdata[GB_NMI];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [SEL_W-1:0] sel_q;
        logic             en_q, ie_q, ifg_q, abt_q;
        logic             ch_wr, crst;

        assign ch_wr = wr && (addr == A_CH0 + AW'(g));
        assign crst  = cmd_wr && wdata[CMD_CRST0 + g];

        // Trigger select field, frozen while the channel is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n || grst) sel_q <= '0;
            else if (sel_wr && !en_q) sel_q <= wdata[g*SEL_W +: SEL_W];
        end

        // Channel control bits with hardware set/clear on top of writes.
        always_ff @(posedge clk) begin
            if (!rst_n || crst) begin
                en_q <= 1'b0; ie_q <= 1'b0; ifg_q <= 1'b0; abt_q <= 1'b0;
            end else begin
                if (ch_wr) begin
                    en_q  <= wdata[CB_EN];
                    ie_q  <= wdata[CB_IE];
                    ifg_q <= wdata[CB_IFG];
                    abt_q <= wdata[CB_ABT];
                end
                if (hw_abort[g]) abt_q <= 1'b1;
                if (hw_done[g]) begin
                    ifg_q <= 1'b1;
                    en_q  <= 1'b0;
                end
            end
        end

        assign sel[g*SEL_W +: SEL_W] = sel_q;
        assign en[g]      = en_q;
        assign ie[g]      = ie_q;
        assign ifg[g]     = ifg_q;
        assign abort_f[g] = abt_q;
        assign sw_req[g]  = ch_wr && wdata[CB_REQ];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_SEL: rdata = DW'(sel);
            A_GLB: begin
                rdata[GB_ROT]   = rot;
                rdata[GB_FETCH] = fetch_wait;
                rdata[GB_NMI]   = nmi_en;
            end
            default: rdata = '0;
        endcase
        for (int k = 0; k < NCH; k++) begin
            if (addr == A_CH0 + AW'(k)) begin
                rdata[CB_EN]  = en[k];
                rdata[CB_IE]  = ie[k];
                rdata[CB_IFG] = ifg[k];
                rdata[CB_ABT] = abort_f[k];
            end
        end
    end
endmodule

// File: rtl/dca_trig.sv
// Trigger selection and rising-edge detection, one detector per channel.
// Assumes trig_bus is synchronous to clk.
module dca_trig #(
    parameter int NCH    = 3,
    parameter int TRIG_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TRIG_W-1:0]    trig_bus,
    input  logic [NCH*SEL_W-1:0] sel,
    output logic [NCH-1:0]       rise
);
    logic [TRIG_W-1:0] prev_q;

    // Previous sample of the whole bus.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= trig_bus;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_edge
        assign rise[g] = trig_bus[sel[g*SEL_W +: SEL_W]] & ~prev_q[sel[g*SEL_W +: SEL_W]];
    end
endmodule

// File: rtl/dca_arb.sv
// Channel arbiter: fixed order, or rotating order starting after the last
// channel served. Purely combinational; output is one-hot or zero.
module dca_arb #(
    parameter int NCH   = 3,
    parameter int PTR_W = 2
) (
    input  logic [NCH-1:0]   elig,
    input  logic             rot,
    input  logic [PTR_W-1:0] last,
    output logic [NCH-1:0]   win
);
    // Scan the candidates in rank order and keep the first eligible one.
    always_comb begin
        int   idx;
        logic found;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            idx = rot ? (int'(last) + 1 + k) % NCH : k;
            if (!found && elig[idx]) begin
                win[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
// Top of the transfer control block: pending requests, grant ownership,
// NMI abort and completion handling. Assumes the engine raises unit_done
// only while it holds a grant.
module dma_chan_arbiter
    import dca_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int TRIG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [TRIG_W-1:0] trig_bus,
    input  logic              nmi,
    input  logic              ifetch,
    input  logic              unit_done,
    input  logic              xfer_last,
    output logic [NCH-1:0]    grant,
    output logic              irq
);
    localparam int SEL_W = $clog2(TRIG_W);
    localparam int PTR_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH*SEL_W-1:0] sel_q;
    logic                 rot, on_fetch, nmi_en;
    logic [NCH-1:0]       en_q, ie_q, ifg_q, abort_q, sw_req, trig_rise;
    logic [NCH-1:0]       pend_q, elig, win, gnt_q, hw_done, hw_abort;
    logic [PTR_W-1:0]     last_q, gnt_idx;
    logic                 idle, stop;

    dca_regs #(.NCH(NCH), .SEL_W(SEL_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .hw_done(hw_done), .hw_abort(hw_abort), .sel(sel_q), .rot(rot),
        .fetch_wait(on_fetch), .nmi_en(nmi_en), .en(en_q), .ie(ie_q), .ifg(ifg_q),
        .abort_f(abort_q), .sw_req(sw_req), .rdata(reg_rdata)
    );

    dca_trig #(.NCH(NCH), .TRIG_W(TRIG_W), .SEL_W(SEL_W)) i_trig (
        .clk(clk), .rst_n(rst_n), .trig_bus(trig_bus), .sel(sel_q), .rise(trig_rise)
    );

    dca_arb #(.NCH(NCH), .PTR_W(PTR_W)) i_arb (
        .elig(elig), .rot(rot), .last(last_q), .win(win)
    );

    assign idle     = (gnt_q == '0);
    assign elig     = pend_q & en_q & {NCH{!on_fetch || ifetch}};
    assign hw_abort = gnt_q & {NCH{nmi && nmi_en}};
    assign stop     = unit_done && (xfer_last || (|(gnt_q & (abort_q | hw_abort))));
    assign hw_done  = gnt_q & {NCH{stop}};
    assign grant    = gnt_q;
    assign irq      = |(ifg_q & ie_q);

    // Index of the channel holding the grant.
    always_comb begin
        gnt_idx = '0;
        for (int k = 0; k < NCH; k++) if (gnt_q[k]) gnt_idx = PTR_W'(k);
    end

    // Grant ownership: issue when idle, release at a unit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            last_q <= PTR_W'(NCH - 1);
        end else if (!idle && unit_done) begin
            gnt_q  <= '0;
            last_q <= gnt_idx;
        end else if (idle) begin
            gnt_q  <= win;
        end
    end

    // Pending requests: set by trigger edge or software, cleared on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else pend_q <= ((pend_q & ~(idle ? win : '0)) | ((sw_req | trig_rise) & en_q)) & en_q;
    end
endmodule

// File: rtl/dca_checker.sv
// Property checker for the transfer control block, attached by bind.
module dca_checker
    import dca_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int SEL_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       grant,
    input logic                 unit_done,
    input logic                 xfer_last,
    input logic                 ifetch,
    input logic                 on_fetch,
    input logic                 nmi,
    input logic                 nmi_en,
    input logic [NCH-1:0]       en,
    input logic [NCH-1:0]       ifg,
    input logic [NCH-1:0]       abort_f,
    input logic                 reg_wr,
    input logic [AW-1:0]        reg_addr,
    input logic [NCH*SEL_W-1:0] sel
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !unit_done) |=> grant == $past(grant)); // R6
    AST_FETCH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && on_fetch && !ifetch) |=> grant == '0); // R5
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && xfer_last && grant != '0 && !reg_wr) |=>
        ((ifg & $past(grant)) != '0) && ((en & $past(grant)) == '0)); // R7
    AST_NMI_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && nmi_en && grant != '0 && !reg_wr) |=> (abort_f & $past(grant)) != '0); // R9
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && (grant & abort_f) != '0) |=> (en & $past(grant)) == '0); // R9

    for (genvar g = 0; g < NCH; g++) begin : g_lock
        AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_SEL && en[g]) |=>
            sel[g*SEL_W +: SEL_W] == $past(sel[g*SEL_W +: SEL_W])); // R2
    end
endmodule

bind dma_chan_arbiter dca_checker #(.NCH(NCH), .SEL_W(SEL_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .unit_done(unit_done),
    .xfer_last(xfer_last), .ifetch(ifetch), .on_fetch(on_fetch), .nmi(nmi),
    .nmi_en(nmi_en), .en(en_q), .ifg(ifg_q), .abort_f(abort_q),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .sel(sel_q)
);

// File: tb/test_dma_chan_arbiter.sv
`timescale 1ns/1ps
module test_dma_chan_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] trig_bus = '0;
    logic        nmi = 1'b0, ifetch = 1'b0, unit_done = 1'b0, xfer_last = 1'b0;
    logic [2:0]  grant;
    logic        irq;

    int n_tests = 0, n_fail = 0, exp_last = 2;
    bit done_flag = 0;

    always #2 clk = ~clk;

    dma_chan_arbiter i_dma_chan_arbiter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_bus(trig_bus),
        .nmi(nmi), .ifetch(ifetch), .unit_done(unit_done), .xfer_last(xfer_last),
        .grant(grant), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic finish(input int ch, input bit last);
        @(negedge clk); unit_done = 1'b1; xfer_last = last;
        @(negedge clk); unit_done = 1'b0; xfer_last = 1'b0;
        exp_last = ch;
    endtask

    function automatic logic [2:0] exp_win(input logic [2:0] m, input bit rotm, input int lst);
        for (int k = 0; k < 3; k++) begin
            int idx = rotm ? (lst + 1 + k) % 3 : k;
            if (m[idx]) return 3'(1 << idx);
        end
        return 3'b000;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd1234));
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state
        for (int a = 0; a < 7; a++) begin
            if (a == 3) continue;
            rd(3'(a), d); check("R10 reset register", d, 16'h0);
        end
        check("R6 reset grant", 16'(grant), 16'h0);
        check("R8 reset irq", 16'(irq), 16'h0);

        // R1 select fields, R2 lock
        wr(3'd0, 16'h0321); rd(3'd0, d); check("R1 select write", d, 16'h0321);
        wr(3'd4, 16'h0001);
        wr(3'd0, 16'h0FFF); rd(3'd0, d); check("R2 enabled field kept", d, 16'h0FF1);

        // R1 trigger edge on line 1 -> channel 0
        step(); trig_bus = 16'h0002;
        step(); check("R6 no grant before pending", 16'(grant), 16'h0);
        step(); check("R1 trigger grant", 16'(grant), 16'h1);
        repeat (3) step();
        check("R6 grant held", 16'(grant), 16'h1);
        finish(0, 0);
        check("R6 grant released", 16'(grant), 16'h0);
        rd(3'd4, d); check("R7 not last keeps enable", d, 16'h0001);
        trig_bus = 16'h0;
        step(); check("R1 level without edge", 16'(grant), 16'h0);

        // R11 software request
        wr(3'd4, 16'h0013);
        rd(3'd4, d); check("R11 request bit reads 0", d, 16'h0003);
        check("R6 one edge latency", 16'(grant), 16'h0);
        step(); check("R11 software grant", 16'(grant), 16'h1);

        // R7 completion, R8 irq
        finish(0, 1);
        rd(3'd4, d); check("R7 flag set enable cleared", d, 16'h0006);
        check("R8 irq on", 16'(irq), 16'h1);
        repeat (3) step();
        rd(3'd4, d); check("R7 flag sticky", d, 16'h0006);
        wr(3'd4, 16'h0002); rd(3'd4, d); check("R7 flag cleared by write", d, 16'h0002);
        check("R8 irq off", 16'(irq), 16'h0);
        wr(3'd4, 16'h0004); check("R8 flag without enable", 16'(irq), 16'h0);
        wr(3'd4, 16'h0000);

        // R5 fetch wait
        wr(3'd1, 16'h0002); rd(3'd1, d); check("R5 mode bit", d, 16'h0002);
        wr(3'd4, 16'h0001); wr(3'd4, 16'h0011);
        repeat (4) step();
        check("R5 held without fetch", 16'(grant), 16'h0);
        ifetch = 1'b1; step(); ifetch = 1'b0;
        check("R5 grant on fetch", 16'(grant), 16'h1);
        finish(0, 1);
        wr(3'd1, 16'h0000); wr(3'd4, 16'h0000);

        // R9 NMI abort
        wr(3'd1, 16'h0004);
        wr(3'd5, 16'h0001); wr(3'd5, 16'h0011); step();
        check("R9 grant ch1", 16'(grant), 16'h2);
        nmi = 1'b1; step(); nmi = 1'b0;
        rd(3'd5, d); check("R9 abort set", d, 16'h0009);
        check("R9 grant kept through abort", 16'(grant), 16'h2);
        finish(1, 0);
        rd(3'd5, d); check("R9 stopped after unit", d, 16'h000C);
        check("R9 grant released", 16'(grant), 16'h0);
        wr(3'd1, 16'h0000);
        wr(3'd5, 16'h0001); wr(3'd5, 16'h0011); step();
        nmi = 1'b1; step(); nmi = 1'b0;
        rd(3'd5, d); check("R9 nmi ignored when disabled", d, 16'h0001);
        finish(1, 1);

        // R10 resets
        wr(3'd5, 16'h0003); wr(3'd1, 16'h0001);
        wr(3'd2, 16'h0020);
        rd(3'd5, d); check("R10 channel reset", d, 16'h0);
        rd(3'd1, d); check("R10 channel reset spares global", d, 16'h0001);
        wr(3'd2, 16'h0001);
        rd(3'd0, d); check("R10 global reset select", d, 16'h0);
        rd(3'd1, d); check("R10 global reset mode", d, 16'h0);

        // Random patterns: R3 fixed and R4 rotating priority
        for (int it = 0; it < 40; it++) begin
            logic [3:0] s0, s1, s2;
            logic [2:0] m, e;
            bit rotm;
            for (int c = 0; c < 3; c++) wr(3'(4 + c), 16'h0);
            s0 = 4'($urandom % 16);
            s1 = 4'((s0 + 1 + $urandom % 15) % 16);
            s2 = 4'($urandom % 16);
            while (s2 == s0 || s2 == s1) s2 = s2 + 4'd1;
            wr(3'd0, {4'h0, s2, s1, s0});
            rotm = 1'($urandom % 2);
            wr(3'd1, {15'h0, rotm});
            for (int c = 0; c < 3; c++) wr(3'(4 + c), 16'h1);
            m = 3'(1 + $urandom % 7);
            step();
            trig_bus = 16'h0;
            if (m[0]) trig_bus[s0] = 1'b1;
            if (m[1]) trig_bus[s1] = 1'b1;
            if (m[2]) trig_bus[s2] = 1'b1;
            step(); step();
            while (m != 3'b000) begin
                e = exp_win(m, rotm, exp_last);
                check(rotm ? "R4 rotating winner" : "R3 fixed winner", 16'(grant), 16'(e));
                for (int c = 0; c < 3; c++) if (e[c]) begin
                    finish(c, 1);
                    m[c] = 1'b0;
                end
                if (e == 3'b000) m = 3'b000;
                if (m != 3'b000) step();
            end
            trig_bus = 16'h0;
            step();
        end

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule